// File: doc/BRIEF.md
# Section Parity Checker with Serial Error-Count Output

This block watches a framed byte stream and checks the section bit-interleaved parity that travels in each frame. It XORs every byte of a frame, taken on the scrambled side of the link, into an 8-bit accumulator. When the next frame begins, the finished value is kept as the reference parity. In that next frame, the byte at a configurable offset is the transmitted parity byte, taken from the descrambled side. The block compares it against the reference.

The number of bit positions that disagree is not given as a binary value. It leaves the block on one wire as a run of pulses. No pulses means the frame was clean, and each mismatched bit adds one pulse, up to eight. Each pulse is high for a fixed number of byte clocks, and the same number of low byte clocks separates it from the next pulse. A result that arrives while an earlier train is still going out waits in a short queue and follows that train.

The framer supplies the frame-start strobe, the in-frame level and the offset of the parity byte. Descrambling and frame alignment happen outside this block. One byte is presented on every clock.

Top module: `sect_bip_monitor`

## Requirements
- R1: While reset is asserted, and after it until the first comparison result, `err_pulse` is low.
- R2: The reference parity is the XOR of every `scr_byte` of one frame, from the byte presented with `frame_start` (offset 0) up to the byte before the next `frame_start`. It is compared with the `dsc_byte` presented at offset `b1_offset` (counted from 0 at the `frame_start` byte, value at least 1) of the following frame.
- R3: The number of pulses equals the count of 1 bits in (reference parity XOR received parity byte), from 0 to 8. A count of 0 leaves `err_pulse` low.
- R4: Every pulse is high for exactly HI_CYC clocks (default 8). Consecutive pulses of a train are separated by exactly LO_CYC low clocks (default 8).
- R5: If no train is active and none is waiting, the first pulse goes high on the second rising clock edge after the edge that samples the parity byte.
- R6: No comparison is made in the first frame after reset, so that frame never produces pulses whatever its parity byte holds.
- R7: While `in_frame` is low, no comparison is made and the reference is discarded. The first frame after `in_frame` returns high produces no pulses.
- R8: A result that arrives while a train is active is queued. Its first pulse goes high exactly LO_CYC low clocks after the last pulse of the active train, or at the R5 time if that is later.
- R9: Only `scr_byte` feeds the parity, and only the offset-`b1_offset` byte of `dsc_byte` is compared. The values of all other descrambled bytes have no effect on `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_frame | input | 1 | High while the framer holds frame alignment |
| frame_start | input | 1 | High with the first byte of each frame |
| scr_byte | input | 8 | Byte as received, before descrambling |
| dsc_byte | input | 8 | Same byte after descrambling |
| b1_offset | input | POS_W | Offset of the parity byte within the frame (at least 1) |
| err_pulse | output | 1 | Serial error-count pulse train |

## Verification
Two functions can meet in one cycle. One is the queue accepting a new comparison result. The other is the pulse generator finishing the last low period of a train and popping the next count. The bench provokes this with 32-byte frames that each carry two errors, so each train lasts exactly one frame and the next parity byte lands on the cycle the generator turns over. A second case uses 40-byte frames with eight errors, so the second result waits in the queue for most of a train. In both cases the bench judges the result by the exact rise cycle of every pulse: the next train must start after exactly eight low clocks, with neither a lost pulse nor an extra idle cycle.

// File: rtl/bip_mon_pkg.sv
package bip_mon_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  errcnt_t;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_HIGH = 2'd1,
        GEN_LOW  = 2'd2
    } gen_state_e;
endpackage

// File: rtl/bip_accum.sv
module bip_accum
    import bip_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_frame,
    input  logic  frame_start,
    input  byte_t scr_byte,
    output byte_t ref_par,
    output logic  ref_valid
);
    typedef struct packed {
        byte_t acc;
        byte_t ref_p;
        logic  seen;
        logic  ref_ok;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!in_frame) begin
            st_d.acc    = '0;
            st_d.seen   = 1'b0;
            st_d.ref_ok = 1'b0;
        end else if (frame_start) begin
            // close the finished frame and restart with this byte
            st_d.ref_p  = st_q.acc;
            st_d.ref_ok = st_q.seen;
            st_d.seen   = 1'b1;
            st_d.acc    = scr_byte;
        end else begin
            st_d.acc = st_q.acc ^ scr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_par   = st_q.ref_p;
    assign ref_valid = st_q.ref_ok;
endmodule

// File: rtl/bip_compare.sv
module bip_compare
    import bip_mon_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_frame,
    input  logic             frame_start,
    input  byte_t            dsc_byte,
    input  logic [POS_W-1:0] b1_offset,
    input  byte_t            ref_par,
    input  logic             ref_valid,
    output logic             hit_push,
    output errcnt_t          hit_cnt
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             done;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    byte_t   diff;
    logic    at_b1;

    function automatic errcnt_t ones(input byte_t v);
        errcnt_t c;
        c = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c + errcnt_t'(v[i]);
        end
        return c;
    endfunction

    always_comb begin
        st_d     = st_q;
        diff     = ref_par ^ dsc_byte;
        hit_cnt  = ones(diff);
        at_b1    = in_frame && !frame_start && !st_q.done && (st_q.pos == b1_offset);
        hit_push = at_b1 && ref_valid && (hit_cnt != '0);
        if (frame_start) begin
            st_d.pos  = POS_W'(1);
            st_d.done = 1'b0;
        end else begin
            if (st_q.pos != '1) st_d.pos = st_q.pos + 1'b1;
            if (at_b1)          st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bip_result_queue.sv
module bip_result_queue
    import bip_mon_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  errcnt_t push_cnt,
    input  logic    pop,
    output errcnt_t head,
    output logic    empty,
    output logic    full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    typedef struct packed {
        errcnt_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]    wp;
        logic [PTR_W-1:0]    rp;
        logic [OCC_W-1:0]    occ;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.occ != '0);
        do_push = push && ((st_q.occ != FULL_OCC) || do_pop);
        if (do_push) begin
            st_d.slot[st_q.wp] = push_cnt;
            st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.occ = st_q.occ + 1'b1;
            2'b01:   st_d.occ = st_q.occ - 1'b1;
            default: st_d.occ = st_q.occ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.slot[st_q.rp];
    assign empty = (st_q.occ == '0);
    assign full  = (st_q.occ == FULL_OCC);
endmodule

// File: rtl/bip_pulse_gen.sv
module bip_pulse_gen
    import bip_mon_pkg::*;
#(
    parameter int HI_CYC = 8,
    parameter int LO_CYC = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    avail,
    input  errcnt_t next_cnt,
    output logic    take,
    output logic    pulse,
    output logic    idle
);
    localparam int TMAX   = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int TICK_W = $clog2(TMAX + 1);
    localparam logic [TICK_W-1:0] HI_LAST = TICK_W'(HI_CYC - 1);
    localparam logic [TICK_W-1:0] LO_LAST = TICK_W'(LO_CYC - 1);

    typedef struct packed {
        gen_state_e        st;
        errcnt_t           left;
        logic [TICK_W-1:0] tick;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        case (st_q.st)
            GEN_IDLE: begin
                if (avail) begin
                    take      = 1'b1;
                    st_d.st   = GEN_HIGH;
                    st_d.left = next_cnt;
                    st_d.tick = '0;
                end
            end
            GEN_HIGH: begin
                if (st_q.tick == HI_LAST) begin
                    st_d.st   = GEN_LOW;
                    st_d.tick = '0;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            GEN_LOW: begin
                if (st_q.tick == LO_LAST) begin
                    st_d.tick = '0;
                    if (st_q.left > errcnt_t'(1)) begin
                        st_d.st   = GEN_HIGH;
                        st_d.left = st_q.left - 1'b1;
                    end else if (avail) begin
                        // chain the queued train with no idle cycle between
                        take      = 1'b1;
                        st_d.st   = GEN_HIGH;
                        st_d.left = next_cnt;
                    end else begin
                        st_d.st   = GEN_IDLE;
                        st_d.left = '0;
                    end
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            default: st_d.st = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = (st_q.st == GEN_HIGH);
    assign idle  = (st_q.st == GEN_IDLE);
endmodule

// File: rtl/sect_bip_monitor.sv
module sect_bip_monitor
    import bip_mon_pkg::*;
#(
    parameter int POS_W  = 16,
    parameter int HI_CYC = 8,
    parameter int LO_CYC = 8,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_frame,
    input  logic              frame_start,
    input  logic [BYTE_W-1:0] scr_byte,
    input  logic [BYTE_W-1:0] dsc_byte,
    input  logic [POS_W-1:0]  b1_offset,
    output logic              err_pulse
);
    byte_t   ref_par;
    logic    ref_valid;
    logic    cmp_push;
    errcnt_t cmp_cnt;
    errcnt_t q_head;
    logic    q_empty, q_full;
    logic    gen_take, gen_idle;

    bip_accum u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_frame    (in_frame),
        .frame_start (frame_start),
        .scr_byte    (scr_byte),
        .ref_par     (ref_par),
        .ref_valid   (ref_valid)
    );

    bip_compare #(.POS_W(POS_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_frame    (in_frame),
        .frame_start (frame_start),
        .dsc_byte    (dsc_byte),
        .b1_offset   (b1_offset),
        .ref_par     (ref_par),
        .ref_valid   (ref_valid),
        .hit_push    (cmp_push),
        .hit_cnt     (cmp_cnt)
    );

    bip_result_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cmp_push),
        .push_cnt (cmp_cnt),
        .pop      (gen_take),
        .head     (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    bip_pulse_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .avail    (!q_empty),
        .next_cnt (q_head),
        .take     (gen_take),
        .pulse    (err_pulse),
        .idle     (gen_idle)
    );
endmodule

// File: rtl/sect_bip_monitor_chk.sv
module sect_bip_monitor_chk #(
    parameter int HI_CYC = 8,
    parameter int LO_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_frame,
    input logic frame_start,
    input logic err_pulse,
    input logic cmp_push,
    input logic q_full,
    input logic q_empty,
    input logic gen_idle
);
    localparam int HW = $clog2(HI_CYC + 2);
    localparam int LW = $clog2(LO_CYC + 1);

    logic [HW-1:0] hi_run_q;
    logic [LW-1:0] lo_run_q;
    logic [1:0]    starts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= LW'(LO_CYC);
            starts_q <= '0;
        end else begin
            if (err_pulse) begin
                hi_run_q <= (hi_run_q != '1) ? hi_run_q + 1'b1 : hi_run_q;
                lo_run_q <= '0;
            end else begin
                hi_run_q <= '0;
                lo_run_q <= (lo_run_q != LW'(LO_CYC)) ? lo_run_q + 1'b1 : lo_run_q;
            end
            if (frame_start && in_frame && starts_q != 2'd2) starts_q <= starts_q + 1'b1;
        end
    end

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_pulse) |-> (hi_run_q == HW'(HI_CYC))); // R4

    AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_pulse) |-> (lo_run_q >= LW'(LO_CYC))); // R4

    AST_QUIET_FIRST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (starts_q < 2'd2) |-> !err_pulse); // R6

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_push && q_empty && gen_idle) |-> ##2 err_pulse); // R5

    AST_QUEUE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_push && q_full)); // R8
endmodule

bind sect_bip_monitor sect_bip_monitor_chk #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_frame    (in_frame),
    .frame_start (frame_start),
    .err_pulse   (err_pulse),
    .cmp_push    (cmp_push),
    .q_full      (q_full),
    .q_empty     (q_empty),
    .gen_idle    (gen_idle)
);

// File: tb/sect_bip_monitor_test.sv
module sect_bip_monitor_test;
    localparam int POS_W = 16;
    localparam int PER   = 16;   // HI_CYC + LO_CYC

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_frame = 1'b0;
    logic             frame_start = 1'b0;
    logic [7:0]       scr_byte = '0;
    logic [7:0]       dsc_byte = '0;
    logic [POS_W-1:0] b1_offset = 16'd20;
    logic             err_pulse;

    always #4 clk = ~clk;   // 125 MHz

    sect_bip_monitor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_frame    (in_frame),
        .frame_start (frame_start),
        .scr_byte    (scr_byte),
        .dsc_byte    (dsc_byte),
        .b1_offset   (b1_offset),
        .err_pulse   (err_pulse)
    );

    int errors = 0;
    int checks = 0;

    // output monitor, sampled 2 ns after each rising edge
    int   cyc = 0;
    int   nrise = 0;
    int   rise_t [0:63];
    int   hi_len = 0;
    int   bad_width = 0;
    logic prev_err = 1'b0;

    always @(posedge clk) begin
        #2;
        cyc++;
        if (err_pulse && !prev_err) begin
            if (nrise < 64) rise_t[nrise] = cyc;
            nrise++;
        end
        if (err_pulse) hi_len++;
        else begin
            if (prev_err && hi_len != 8) bad_width++;
            hi_len = 0;
        end
        prev_err = err_pulse;
    end

    // expectation model
    int         exp_t [0:63];
    int         nexp = 0;
    int         gen_free = 0;
    logic [7:0] prev_par = '0;
    bit         have_ref = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_train(input int b1c, input int n);
        int s;
        s = b1c + 2;
        if (gen_free > s) s = gen_free;
        for (int i = 0; i < n; i++) begin
            if (nexp < 64) exp_t[nexp] = s + PER * i;
            nexp++;
        end
        if (n > 0) gen_free = s + PER * n;
    endtask

    task automatic begin_scn();
        nrise = 0;
        nexp  = 0;
    endtask

    task automatic check_rises(input string req);
        check(nrise == nexp, {req, " pulse count"}, nrise, nexp);
        for (int i = 0; i < nexp && i < nrise && i < 64; i++) begin
            check(rise_t[i] == exp_t[i], {req, " rise cycle"}, rise_t[i], exp_t[i]);
        end
    endtask

    task automatic send_frame(input int len, input logic [7:0] flip, input int seed);
        logic [7:0] par;
        int b1c;
        par = '0;
        b1c = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_frame    = 1'b1;
            frame_start = (i == 0);
            scr_byte    = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
            if (i == int'(b1_offset)) begin
                dsc_byte = prev_par ^ flip;
                b1c      = cyc;
            end else begin
                dsc_byte = 8'(i * 13 + seed * 7);
            end
            par ^= scr_byte;
        end
        if (have_ref) expect_train(b1c, $countones(flip));
        prev_par = par;
        have_ref = 1'b1;
    endtask

    task automatic idle(input int k, input logic inf);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_frame    = inf;
            frame_start = 1'b0;
            scr_byte    = '0;
            dsc_byte    = '0;
        end
        if (!inf) have_ref = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(err_pulse == 1'b0, "R1 in reset", int'(err_pulse), 0);
        rst_n = 1'b1;
        idle(6, 1'b1);
        check(err_pulse == 1'b0, "R1 after reset", int'(err_pulse), 0);
    endtask

    task automatic t_first_frame();
        begin_scn();
        send_frame(160, 8'hFF, 1);      // no reference yet
        idle(10, 1'b1);
        check_rises("R6");
        begin_scn();
        send_frame(160, 8'h00, 2);      // clean parity byte
        idle(20, 1'b1);
        check_rises("R3 zero");
    endtask

    task automatic t_patterns();
        begin_scn();
        send_frame(160, 8'h01, 3);
        send_frame(160, 8'h81, 4);
        send_frame(160, 8'h5A, 5);
        send_frame(160, 8'hFF, 6);
        idle(150, 1'b1);
        check_rises("R2 R3 R5");
    endtask

    task automatic t_ignore_dsc();
        begin_scn();
        send_frame(160, 8'h00, 40);
        send_frame(160, 8'h00, 77);
        send_frame(160, 8'h10, 91);
        idle(40, 1'b1);
        check_rises("R9");
    endtask

    task automatic t_loss();
        begin_scn();
        idle(12, 1'b0);
        send_frame(160, 8'hFF, 8);      // first frame after realignment
        send_frame(160, 8'h03, 9);
        idle(60, 1'b1);
        check_rises("R7");
    endtask

    task automatic t_queue();
        begin_scn();
        send_frame(40, 8'hFF, 10);
        send_frame(40, 8'h07, 11);      // arrives mid-train
        idle(300, 1'b1);
        check_rises("R8 queued");
    endtask

    task automatic t_adjacent();
        begin_scn();
        send_frame(32, 8'h03, 12);
        send_frame(32, 8'h03, 13);      // lands as previous train ends
        send_frame(32, 8'h03, 14);
        idle(120, 1'b1);
        check_rises("R8 back-to-back");
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_patterns();
        t_ignore_dsc();
        t_loss();
        t_queue();
        t_adjacent();
        check(bad_width == 0, "R4 high width", bad_width, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule